// File: doc/BRIEF.md
# Indexed Precision Colour Lookup with Chained Curves

This block is the colour correction table of a display pipe. One RAM of 1024 words, each holding three 10-bit channel values, is loaded by a host through a small register port. The host sets an index word, which holds the table address, an auto-advance flag and a half-wrap flag. It then streams entries through a data register. The same RAM serves three ways. In legacy mode it is a 256-entry palette with 8 bits per channel. In ten-bit mode it is one 1024-entry curve. In split mode the lower half is a linearising curve whose output feeds a second curve held in the upper half.

Pixels arrive as three 11-bit channels. Bit 10 of a channel marks a value of 1.0 or more. Pixels leave as three 16-bit channels. The stream has valid/ready handshakes on both sides. A pixel is accepted on a rising edge where `pix_in_valid` and `pix_in_ready` are both high, and it appears on the output four accepted steps later. The whole pipeline moves only when the output slot is empty or is being taken, so `pix_in_ready` equals `!pix_out_valid || pix_out_ready`. Stalled output data stays unchanged. Pixels leave in the order they arrived. Each pixel keeps the mode that was set when it was accepted. The mode register should only be changed while no pixels are in flight.

Top module: `color_lut_pipe`

## Requirements
- R1: After reset the index word is 0, all three clamp registers read 0xFFFF, the mode reads 0 (legacy) and `pix_out_valid` is low.
- R2: Register offsets are 0 index, 1 data, 2/3/4 red/green/blue clamp, and 5 mode. In the index word, bits 9:0 hold the address, bit 15 the auto-advance flag and bit 31 the half-wrap flag, and the word reads back as written. A read returns its value on `reg_rdata` from the cycle after `reg_rd`, and other offsets read 0.
- R3: A data-register write stores the entry at the current address. Only when auto-advance is set does the address then step by one. With the flag clear the address stays put.
- R4: A data-register read returns the entry at the current address. It steps the address in the same way as a write.
- R5: In ten-bit mode (mode 1, and also mode 3) a table word holds red in 29:20, green in 19:10 and blue in 9:0. Each channel's 10-bit value addresses the table directly, and the output is the channel's field shifted left by 6.
- R6: With the half-wrap flag set in ten-bit or split mode, stepping keeps the top address bit, so 511 goes to 0 and 1023 goes to 512. With the flag clear, 1023 goes to 0.
- R7: In split mode (mode 2) a channel value v reads entry v[9:1] from the lower half to get d. It then reads entry 512 + d[9:1] from the upper half, and the output is that field shifted left by 6.
- R8: In ten-bit and split modes a channel with bit 10 set outputs its 16-bit clamp register instead of a table value.
- R9: In legacy mode the address is the index modulo 256 and steps 255 to 0. A data write keeps only bits 23:0 (red 23:16, green 15:8, blue 7:0), and a data read returns those bits with the rest zero. A pixel channel reads entry v[9:2], or entry 255 when bit 10 is set, and outputs its byte shifted left by 8.
- R10: Any write to the mode register clears the address and both index flags.
- R11: Output follows input with a latency of four accepted steps, in order. While `pix_out_valid` is high and `pix_out_ready` low, the output holds and no input is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted this edge |
| pix_in_r | input | 11 | Red in, bit 10 = 1.0 or more |
| pix_in_g | input | 11 | Green in |
| pix_in_b | input | 11 | Blue in |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Sink takes output |
| pix_out_r | output | 16 | Red out |
| pix_out_g | output | 16 | Green out |
| pix_out_b | output | 16 | Blue out |

## Verification
The bench goes after the address-stepping corners: 1023 wrapping to 0, the half-wrap flag folding 1023 to 512, and legacy folding 255 to 0. A design that got any of these wrong would write entries into the wrong half or past the palette, and that shows up in later read-backs and pixel values. It checks that a mode write clears a stale auto-advance index, since otherwise a later legacy write would land at an old address. In split mode it checks that the second lookup is taken from the upper half using the first curve's result; a design that reused the raw input or the lower half would produce visibly different outputs. Super-unity channels must show the clamp register in the wide modes and entry 255 in legacy. A random-looking output stall pattern checks that no pixel is dropped, duplicated or reordered.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    LM_LEGACY = 2'd0,
    LM_TEN    = 2'd1,
    LM_SPLIT  = 2'd2,
    LM_TEN_B  = 2'd3
  } lut_mode_e;

  localparam int RA_W = 3;
  localparam logic [RA_W-1:0] RA_INDEX = 3'd0;
  localparam logic [RA_W-1:0] RA_DATA  = 3'd1;
  localparam logic [RA_W-1:0] RA_MAXR  = 3'd2;
  localparam logic [RA_W-1:0] RA_MAXG  = 3'd3;
  localparam logic [RA_W-1:0] RA_MAXB  = 3'd4;
  localparam logic [RA_W-1:0] RA_MODE  = 3'd5;

  localparam int IDX_AUTO_BIT  = 15;
  localparam int IDX_SPLIT_BIT = 31;
endpackage

// File: rtl/clut_store.sv
module clut_store #(
  parameter int AW = 10,
  parameter int DW = 30,
  parameter int NP = 6
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   hrd_en,
  input  logic [AW-1:0]          hrd_addr,
  output logic [DW-1:0]          hrd_data,
  input  logic                   px_en,
  input  logic [NP-1:0][AW-1:0]  px_addr,
  output logic [NP-1:0][DW-1:0]  px_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (hrd_en) hrd_data <= mem[hrd_addr];
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (px_en) px_data[p] <= mem[px_addr[p]];
    end
  end
endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CH_W  = 10,
  parameter int LEG_W = 8,
  parameter int OUT_W = 16,
  parameter int RW    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [RW-1:0]           reg_wdata,
  output logic [RW-1:0]           reg_rdata,
  output lut_mode_e               mode_o,
  output logic [2:0][OUT_W-1:0]   maxv_o,
  output logic                    st_wr_en,
  output logic [AW-1:0]           st_wr_addr,
  output logic [3*CH_W-1:0]       st_wr_data,
  output logic                    st_rd_en,
  output logic [AW-1:0]           st_rd_addr,
  input  logic [3*CH_W-1:0]       st_rd_data
);
  localparam int DW   = 3 * CH_W;
  localparam int LDW  = 3 * LEG_W;
  localparam int APAD = AW - LEG_W;

  logic [AW-1:0]         idx, idx_inc, acc_addr;
  logic                  auto_inc, split_f;
  lut_mode_e             mode;
  logic [2:0][OUT_W-1:0] maxv;
  logic [RW-1:0]         rd_hold, idx_word;
  logic                  rd_store, rd_leg;
  logic                  is_leg, data_wr, data_rd;
  logic                  unused_bits;

  assign is_leg  = (mode == LM_LEGACY);
  assign data_wr = reg_wr && (reg_addr == RA_DATA);
  assign data_rd = !reg_wr && reg_rd && (reg_addr == RA_DATA);
  assign unused_bits = ^reg_wdata[RW-2:DW];

  always_comb begin
    acc_addr = is_leg ? {{APAD{1'b0}}, idx[LEG_W-1:0]} : idx;
    if (is_leg)
      idx_inc = {{APAD{1'b0}}, LEG_W'(idx[LEG_W-1:0] + 1'b1)};
    else if (split_f)
      idx_inc = {idx[AW-1], (AW-1)'(idx[AW-2:0] + 1'b1)};
    else
      idx_inc = AW'(idx + 1'b1);
    idx_word = '0;
    idx_word[AW-1:0] = idx;
    idx_word[IDX_AUTO_BIT] = auto_inc;
    idx_word[IDX_SPLIT_BIT] = split_f;
  end

  assign st_wr_en   = data_wr;
  assign st_wr_addr = acc_addr;
  assign st_wr_data = is_leg ? {{(DW-LDW){1'b0}}, reg_wdata[LDW-1:0]} : reg_wdata[DW-1:0];
  assign st_rd_en   = data_rd;
  assign st_rd_addr = acc_addr;

  assign reg_rdata = rd_store ?
                     (rd_leg ? {{(RW-LDW){1'b0}}, st_rd_data[LDW-1:0]}
                             : {{(RW-DW){1'b0}}, st_rd_data})
                     : rd_hold;
  assign mode_o = mode;
  assign maxv_o = maxv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      auto_inc <= 1'b0;
      split_f  <= 1'b0;
      mode     <= LM_LEGACY;
      maxv     <= '1;
      rd_hold  <= '0;
      rd_store <= 1'b0;
      rd_leg   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_INDEX: begin
          idx      <= reg_wdata[AW-1:0];
          auto_inc <= reg_wdata[IDX_AUTO_BIT];
          split_f  <= reg_wdata[IDX_SPLIT_BIT];
        end
        RA_DATA:  if (auto_inc) idx <= idx_inc;
        RA_MAXR:  maxv[0] <= reg_wdata[OUT_W-1:0];
        RA_MAXG:  maxv[1] <= reg_wdata[OUT_W-1:0];
        RA_MAXB:  maxv[2] <= reg_wdata[OUT_W-1:0];
        RA_MODE: begin
          mode     <= lut_mode_e'(reg_wdata[1:0]);
          idx      <= '0;
          auto_inc <= 1'b0;
          split_f  <= 1'b0;
        end
        default: ;
      endcase
    end else if (reg_rd) begin
      rd_store <= (reg_addr == RA_DATA);
      rd_leg   <= is_leg;
      if (reg_addr == RA_DATA && auto_inc) idx <= idx_inc;
      case (reg_addr)
        RA_INDEX: rd_hold <= idx_word;
        RA_MAXR:  rd_hold <= RW'(maxv[0]);
        RA_MAXG:  rd_hold <= RW'(maxv[1]);
        RA_MAXB:  rd_hold <= RW'(maxv[2]);
        RA_MODE:  rd_hold <= RW'(mode);
        default:  rd_hold <= '0;
      endcase
    end
  end

  // R3: an auto-advancing wide-mode write steps the address by one
  p_autoinc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && auto_inc && !is_leg && !split_f) |=> (idx == AW'($past(idx) + 1'b1)));

  // R3: without auto-advance a data access leaves the address alone
  p_noinc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || data_rd) && !auto_inc) |=> $stable(idx));

  // R6: half-wrap stepping never changes the top address bit
  p_half_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || data_rd) && auto_inc && split_f && !is_leg) |=> (idx[AW-1] == $past(idx[AW-1])));

  // R9: legacy stepping folds 255 back to 0
  p_leg_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && auto_inc && is_leg && (idx[LEG_W-1:0] == '1)) |=> (idx == '0));

  // R10: a mode write leaves no stale index state
  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_MODE) |=> (idx == '0 && !auto_inc && !split_f));
endmodule

// File: rtl/clut_stage.sv
module clut_stage
  import clut_pkg::*;
#(
  parameter int AW       = 10,
  parameter int CH_W     = 10,
  parameter int LEG_W    = 8,
  parameter int OUT_W    = 16,
  parameter bit IS_GAMMA = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        in_valid,
  input  lut_mode_e                   in_mode,
  input  logic [2:0]                  in_over,
  input  logic [2:0][OUT_W-1:0]       in_val,
  output logic [2:0][AW-1:0]          rd_addr,
  input  logic [2:0][3*CH_W-1:0]      rd_data,
  output logic                        out_valid,
  output lut_mode_e                   out_mode,
  output logic [2:0]                  out_over,
  output logic [2:0][OUT_W-1:0]       out_val
);
  localparam int HW   = AW - 1;
  localparam int PAD  = OUT_W - CH_W;
  localparam int LPAD = OUT_W - LEG_W;
  localparam int APAD = AW - LEG_W;

  logic                  n_look;
  logic [2:0][AW-1:0]    n_addr;
  logic [2:0]            n_over;

  logic                  a_valid, a_look;
  lut_mode_e             a_mode;
  logic [2:0]            a_over;
  logic [2:0][AW-1:0]    a_addr;
  logic [2:0][OUT_W-1:0] a_val;

  logic                  b_valid, b_look;
  lut_mode_e             b_mode;
  logic [2:0]            b_over;
  logic [2:0][OUT_W-1:0] b_val;

  always_comb begin
    n_look = 1'b0;
    n_addr = '0;
    n_over = '0;
    for (int c = 0; c < 3; c++) begin
      case (in_mode)
        LM_LEGACY: begin
          n_look    = !IS_GAMMA;
          n_addr[c] = in_over[c] ? {{APAD{1'b0}}, {LEG_W{1'b1}}}
                                 : {{APAD{1'b0}}, in_val[c][OUT_W-1 -: LEG_W]};
          n_over[c] = 1'b0;
        end
        LM_SPLIT: begin
          n_look    = 1'b1;
          n_addr[c] = {IS_GAMMA, in_over[c] ? {HW{1'b1}} : in_val[c][OUT_W-1 -: HW]};
          n_over[c] = in_over[c];
        end
        default: begin
          n_look    = !IS_GAMMA;
          n_addr[c] = in_over[c] ? {AW{1'b1}} : in_val[c][OUT_W-1 -: AW];
          n_over[c] = in_over[c];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0; a_look <= 1'b0; a_mode <= LM_LEGACY;
      a_over  <= '0;   a_addr <= '0;   a_val  <= '0;
      b_valid <= 1'b0; b_look <= 1'b0; b_mode <= LM_LEGACY;
      b_over  <= '0;   b_val  <= '0;
    end else if (adv) begin
      a_valid <= in_valid;
      a_look  <= n_look;
      a_mode  <= in_mode;
      a_over  <= n_over;
      a_addr  <= n_addr;
      a_val   <= in_val;
      b_valid <= a_valid;
      b_look  <= a_look;
      b_mode  <= a_mode;
      b_over  <= a_over;
      b_val   <= a_val;
    end
  end

  assign rd_addr   = a_addr;
  assign out_valid = b_valid;
  assign out_mode  = b_mode;
  assign out_over  = b_over;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      if (!b_look)
        out_val[c] = b_val[c];
      else if (b_mode == LM_LEGACY)
        out_val[c] = {rd_data[c][(2-c)*LEG_W +: LEG_W], {LPAD{1'b0}}};
      else
        out_val[c] = {rd_data[c][(2-c)*CH_W +: CH_W], {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/color_lut_pipe.sv
module color_lut_pipe
  import clut_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CH_W  = 10,
  parameter int LEG_W = 8,
  parameter int OUT_W = 16,
  parameter int RW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [CH_W:0]     pix_in_r,
  input  logic [CH_W:0]     pix_in_g,
  input  logic [CH_W:0]     pix_in_b,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [OUT_W-1:0]  pix_out_r,
  output logic [OUT_W-1:0]  pix_out_g,
  output logic [OUT_W-1:0]  pix_out_b
);
  localparam int DW  = 3 * CH_W;
  localparam int NP  = 6;
  localparam int PAD = OUT_W - CH_W;

  lut_mode_e              mode;
  logic [2:0][OUT_W-1:0]  maxv;
  logic                   st_wr_en, st_rd_en, adv;
  logic [AW-1:0]          st_wr_addr, st_rd_addr;
  logic [DW-1:0]          st_wr_data, st_rd_data;
  logic [NP-1:0][AW-1:0]  px_addr;
  logic [NP-1:0][DW-1:0]  px_data;

  logic [2:0]             s1_in_over, s1_out_over, s2_out_over;
  logic [2:0][OUT_W-1:0]  s1_in_val, s1_out_val, s2_out_val, fin;
  logic [2:0][AW-1:0]     s1_rd_addr, s2_rd_addr;
  logic                   s1_out_valid, s2_out_valid;
  lut_mode_e              s1_out_mode, s2_out_mode;

  assign adv          = !pix_out_valid || pix_out_ready;
  assign pix_in_ready = adv;

  assign s1_in_over = {pix_in_b[CH_W], pix_in_g[CH_W], pix_in_r[CH_W]};
  assign s1_in_val[0] = {pix_in_r[CH_W-1:0], {PAD{1'b0}}};
  assign s1_in_val[1] = {pix_in_g[CH_W-1:0], {PAD{1'b0}}};
  assign s1_in_val[2] = {pix_in_b[CH_W-1:0], {PAD{1'b0}}};

  clut_ctrl #(.AW(AW), .CH_W(CH_W), .LEG_W(LEG_W), .OUT_W(OUT_W), .RW(RW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_o(mode), .maxv_o(maxv),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data));

  clut_store #(.AW(AW), .DW(DW), .NP(NP)) store_i (
    .clk(clk), .wr_en(st_wr_en), .wr_addr(st_wr_addr), .wr_data(st_wr_data),
    .hrd_en(st_rd_en), .hrd_addr(st_rd_addr), .hrd_data(st_rd_data),
    .px_en(adv), .px_addr(px_addr), .px_data(px_data));

  assign px_addr = {s2_rd_addr, s1_rd_addr};

  clut_stage #(.AW(AW), .CH_W(CH_W), .LEG_W(LEG_W), .OUT_W(OUT_W), .IS_GAMMA(1'b0)) stage_lo_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(pix_in_valid), .in_mode(mode),
    .in_over(s1_in_over), .in_val(s1_in_val), .rd_addr(s1_rd_addr), .rd_data(px_data[2:0]),
    .out_valid(s1_out_valid), .out_mode(s1_out_mode), .out_over(s1_out_over),
    .out_val(s1_out_val));

  clut_stage #(.AW(AW), .CH_W(CH_W), .LEG_W(LEG_W), .OUT_W(OUT_W), .IS_GAMMA(1'b1)) stage_hi_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(s1_out_valid), .in_mode(s1_out_mode),
    .in_over(s1_out_over), .in_val(s1_out_val), .rd_addr(s2_rd_addr), .rd_data(px_data[5:3]),
    .out_valid(s2_out_valid), .out_mode(s2_out_mode), .out_over(s2_out_over),
    .out_val(s2_out_val));

  always_comb begin
    for (int c = 0; c < 3; c++)
      fin[c] = s2_out_over[c] ? maxv[c] : s2_out_val[c];
  end

  assign pix_out_valid = s2_out_valid;
  assign pix_out_r     = fin[0];
  assign pix_out_g     = fin[1];
  assign pix_out_b     = fin[2];

  // R11: a stalled output keeps its pixel unchanged
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready && !reg_wr) |=>
      (pix_out_valid && $stable(pix_out_r) && $stable(pix_out_g) && $stable(pix_out_b)));

  // R9: legacy pixels never reach the clamp substitution
  p_leg_no_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_out_valid && s1_out_mode == LM_LEGACY) |-> (s1_out_over == 3'b000));

  // R8: only wide-mode pixels carry a super-unity mark to the output
  p_over_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_out_valid && s2_out_over != 3'b000) |-> (s2_out_mode != LM_LEGACY));
endmodule

// File: tb/color_lut_pipe_tb.sv
`timescale 1ns/1ps
module color_lut_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_in_valid = 1'b0, pix_in_ready;
  logic [10:0] pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
  logic        pix_out_valid, pix_out_ready = 1'b1;
  logic [15:0] pix_out_r, pix_out_g, pix_out_b;

  always #2.5 clk = ~clk;

  color_lut_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in_valid(pix_in_valid),
    .pix_in_ready(pix_in_ready), .pix_in_r(pix_in_r), .pix_in_g(pix_in_g),
    .pix_in_b(pix_in_b), .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
    .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b));

  localparam logic [31:0] AUTO  = 32'h0000_8000;
  localparam logic [31:0] HALFW = 32'h8000_0000;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [29:0] mdl [1024];
  logic [15:0] maxv [3];
  int cur_mode = 0;
  bit stall_en = 0;
  int cyc = 0;
  logic [47:0] exp_q [$];
  string tag_q [$];
  string pix_tag = "R5";

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    #1 check(tag, 48'(reg_rdata), 48'(exp));
  endtask

  function automatic logic [29:0] tbl(int i);
    return {10'(i), 10'(1023 - i), 10'((i * 37) % 1024)};
  endfunction

  function automatic logic [15:0] exp_ch(int c, logic [10:0] v);
    logic [9:0] d, o;
    logic [7:0] a8;
    if (cur_mode == 0) begin
      a8 = v[10] ? 8'hFF : v[9:2];
      return {mdl[a8][(2-c)*8 +: 8], 8'h00};
    end
    if (v[10]) return maxv[c];
    if (cur_mode == 2) begin
      d = mdl[{1'b0, v[9:1]}][(2-c)*10 +: 10];
      o = mdl[{1'b1, d[9:1]}][(2-c)*10 +: 10];
      return {o, 6'h0};
    end
    return {mdl[v[9:0]][(2-c)*10 +: 10], 6'h0};
  endfunction

  task automatic send(logic [10:0] r, logic [10:0] g, logic [10:0] b);
    exp_q.push_back({exp_ch(0, r), exp_ch(1, g), exp_ch(2, b)});
    tag_q.push_back(pix_tag);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_r = r; pix_in_g = g; pix_in_b = b;
    #1;
    while (!pix_in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 pix_in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 500) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R11 drain", 48'(exp_q.size()), 48'd0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      pix_out_ready <= !stall_en || ((cyc % 3) != 1 && (cyc % 7) != 2);
      #1;
      if (rst_n && pix_out_valid && pix_out_ready) begin
        if (exp_q.size() == 0) check("R11 unexpected", 48'h1, 48'h0);
        else check(tag_q.pop_front(), {pix_out_r, pix_out_g, pix_out_b}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) maxv[c] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 48'(pix_out_valid), 48'd0);
    rd(3'd0, 32'h0, "R1 index");
    rd(3'd2, 32'hFFFF, "R1 maxr");
    rd(3'd4, 32'hFFFF, "R1 maxb");
    rd(3'd5, 32'h0, "R1 mode");
    // R2 index readback and unused offset
    wr(3'd0, HALFW | AUTO | 32'd5);
    rd(3'd0, HALFW | AUTO | 32'd5, "R2 index");
    rd(3'd7, 32'h0, "R2 unused offset");
    // ten-bit mode, full table load (R10 also clears the index)
    wr(3'd5, 32'd1); cur_mode = 1;
    rd(3'd0, 32'h0, "R10 mode clears index");
    wr(3'd0, AUTO);
    for (int i = 0; i < 1024; i++) begin
      wr(3'd1, {2'b11, tbl(i)});
      mdl[i] = tbl(i);
    end
    rd(3'd0, AUTO, "R6 plain wrap 1023 to 0");
    // R4 read with auto-advance
    wr(3'd0, AUTO | 32'd10);
    rd(3'd1, {2'b0, tbl(10)}, "R4 data read");
    rd(3'd0, AUTO | 32'd11, "R4 read advances");
    // R3 writes without and with auto-advance
    wr(3'd0, 32'd20);
    wr(3'd1, 32'h1234_5678); mdl[20] = 30'h1234_5678;
    rd(3'd0, 32'd20, "R3 no advance");
    rd(3'd1, 32'h1234_5678, "R3 stored");
    wr(3'd0, AUTO | 32'd30);
    wr(3'd1, {2'b0, tbl(30)}); wr(3'd1, {2'b0, tbl(31)});
    rd(3'd0, AUTO | 32'd32, "R3 advance");
    // R5 ten-bit pixels, R8 clamp
    wr(3'd3, 32'h1234); maxv[1] = 16'h1234;
    rd(3'd3, 32'h1234, "R8 maxg readback");
    pix_tag = "R5";
    for (int k = 0; k < 12; k++)
      send(11'((k * 53) % 1024), 11'((k * 101 + 7) % 1024), 11'((k * 13) % 1024));
    pix_tag = "R8";
    send(11'h400, 11'h5FF, 11'd3);
    send(11'd1023, 11'h7FF, 11'h401);
    drain();
    // R7 split mode, R6 half wrap
    wr(3'd5, 32'd2); cur_mode = 2;
    wr(3'd0, HALFW | AUTO | 32'd1022);
    wr(3'd1, {2'b0, tbl(5)});   mdl[1022] = tbl(5);
    wr(3'd1, {2'b0, tbl(900)}); mdl[1023] = tbl(900);
    wr(3'd1, {2'b0, tbl(77)});  mdl[512] = tbl(77);
    rd(3'd0, HALFW | AUTO | 32'd513, "R6 half wrap 1023 to 512");
    wr(3'd0, HALFW | AUTO | 32'd511);
    rd(3'd1, {2'b0, mdl[511]}, "R6 read at 511");
    rd(3'd0, HALFW | AUTO | 32'd0, "R6 half wrap 511 to 0");
    stall_en = 1;
    pix_tag = "R7";
    for (int k = 0; k < 16; k++)
      send(11'((k * 61 + 1) % 1024), 11'((k * 29 + 900) % 1024), 11'((k * 127) % 1024));
    pix_tag = "R8";
    send(11'h4AA, 11'd1023, 11'h7FF);
    drain();
    stall_en = 0;
    // R9 legacy mode
    wr(3'd5, 32'd0); cur_mode = 0;
    wr(3'd0, AUTO);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] w;
      w = {8'hC3, 8'(i), 8'(255 - i), 8'(i) ^ 8'h5A};
      wr(3'd1, w);
      mdl[i] = {6'b0, w[23:0]};
    end
    rd(3'd0, AUTO, "R9 wrap 255 to 0");
    wr(3'd0, AUTO | 32'd254);
    wr(3'd1, 32'hFF11_2233); mdl[254] = 30'h0011_2233;
    wr(3'd1, 32'h00AB_CDEF); mdl[255] = 30'h00AB_CDEF;
    wr(3'd1, 32'h0044_5566); mdl[0]   = 30'h0044_5566;
    rd(3'd0, AUTO | 32'd1, "R9 legacy fold");
    wr(3'd0, 32'd254);
    rd(3'd1, 32'h0011_2233, "R9 legacy read masks");
    // R10 stale index cleared by mode write
    wr(3'd0, HALFW | AUTO | 32'd700);
    wr(3'd5, 32'd0);
    rd(3'd0, 32'h0, "R10 stale index cleared");
    wr(3'd1, 32'h0077_8899); mdl[0] = 30'h0077_8899;
    rd(3'd0, 32'h0, "R10 no advance after clear");
    stall_en = 1;
    pix_tag = "R9";
    for (int k = 0; k < 10; k++)
      send(11'((k * 97) % 1024), 11'((k * 41 + 3) % 1024), 11'((k * 7) % 1024));
    send(11'h400, 11'd2, 11'h7FF);
    pix_tag = "R11";
    for (int k = 0; k < 8; k++) send(11'(k * 4), 11'(1020 - k * 4), 11'(k * 128));
    drain();
    stall_en = 0;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule